// File: doc/BRIEF.md
# Write-Only I2C Configuration Slave for a Stereo Audio Converter

This block is the control port of a stereo audio converter. It listens on a two-wire I2C bus as a slave at the 7-bit address 0x4D and accepts only write transfers. Each transfer carries a subaddress byte followed by one or two data bytes. The subaddress holds a two-bit chip select and a two-bit register index. The slave turns the accepted bytes into three write-only configuration registers. Their fields are brought out as plain outputs that steer the converter: the serial-audio format and rate, the two channel volumes, de-emphasis, the oscillator override, the supply and power mode, the auxiliary input routing and the inversion of the right amplifier.

Two strap pins set the chip select, so up to four such slaves can share one bus. When both straps are high, the mode reserved for an external decoder applies, and the slave answers only to chip select 3. Both bus lines are brought into the system clock domain and oversampled. Start and stop conditions are detected from the synchronized samples, independently of the bit counter. SDA is only ever pulled low, through an output-enable.

The volume register is 16 bits wide. It is written as two bytes, most significant byte first. It changes in one step, and only once the second byte has been acknowledged.

Top module: `dac_cfg_i2c`

## Requirements
- R1: A first byte equal to 0x9A (address 0x4D, bit 0 = 0 meaning write) is acknowledged. Any other address, or the read bit set, is not acknowledged, and the rest of that transfer changes nothing.
- R2: Subaddress bits 7:6 must equal {strapHi, strapLo}, which gives chip select 3 when both straps are 1. On a mismatch the subaddress is not acknowledged and no register changes. Subaddress bits 5:2 are ignored.
- R3: Subaddress bits 1:0 pick the register: 01 is rate, 10 is volume, 11 is configuration. Index 00 is not acknowledged and changes nothing.
- R4: The volume register takes two data bytes, high byte first. Its outputs keep their old value after the first byte and update together only after the second byte has been acknowledged.
- R5: The rate and configuration registers take exactly one data byte, and the volume register takes exactly two. Any further data byte in the same transfer is not acknowledged and is ignored.
- R6: Rate byte mapping: bit 4 drives lrSwap, bit 3 drives delayEn, and bits 2:0 drive rateCode. Bits 7:5 are ignored.
- R7: Volume word mapping: bit 15 drives oscForce, bit 14 drives deemEn, bits 13:8 drive volLeft, and bits 5:0 drive volRight. Bits 7:6 are ignored.
- R8: Configuration byte mapping: bit 7 drives hiSupply, bits 6:4 drive powerMode, bit 3 drives aux2En, bit 2 drives aux1En, bit 1 drives auxMono, and bit 0 drives invRightAmp.
- R9: While rstN is low, every field output is 0. After release, both volume fields load 101100 (0 dB), and every other field stays 0.
- R10: The slave pulls SDA low only during the ninth clock of an accepted byte. It releases SDA at all other times.
- R11: A start condition, including a repeated start in the middle of a transfer, begins a new transfer at the address byte. A volume write cut short by a repeated start leaves the volume outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen on the pin |
| sdaIn | input | 1 | Bus data line as seen on the pin |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| strapHi | input | 1 | Chip-select strap, compared with subaddress bit 7 |
| strapLo | input | 1 | Chip-select strap, compared with subaddress bit 6 |
| rateCode | output | 3 | Sample-rate range code |
| delayEn | output | 1 | One-bit delay after a word-select edge |
| lrSwap | output | 1 | Word-select polarity swap |
| oscForce | output | 1 | Keeps the oscillator running |
| deemEn | output | 1 | De-emphasis network enable |
| volLeft | output | 6 | Left channel volume code |
| volRight | output | 6 | Right channel volume code |
| hiSupply | output | 1 | Selects the 5 V supply mode |
| powerMode | output | 3 | Converter and power mode code |
| aux2En | output | 1 | Second auxiliary input enable |
| aux1En | output | 1 | First auxiliary input enable |
| auxMono | output | 1 | Auxiliary inputs mixed to mono |
| invRightAmp | output | 1 | Right output amplifier inverted |

## Verification
Several rules are checked by the assertions on every cycle. Each field register holds its value unless a write strobe for that register arrives. The volume outputs move only on the strobe of the second byte. No strobe follows a byte that was not acknowledged. SDA is driven only inside an acknowledge slot, never while idle. Address and chip-select matching, the byte-to-field mappings, the reset defaults and the effect of a repeated start can only be shown by the bench. It sweeps every strap setting against every chip-select value and every register index, and predicts the acknowledges and the field values arithmetically.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;

  localparam logic [1:0] REG_RATE = 2'b01;
  localparam logic [1:0] REG_VOL  = 2'b10;
  localparam logic [1:0] REG_CFG  = 2'b11;

  typedef struct packed {
    logic       wrEn;
    logic [1:0] regSel;
    logic [1:0] byteIdx;
    logic [7:0] data;
  } cfgStrobe_t;

endpackage

// File: rtl/dac_cfg_sync.sv
module dac_cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= RST_VAL;
        else       chain <= d;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= {STAGES{RST_VAL}};
        else       chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dac_cfg_ctrl.sv
module dac_cfg_ctrl
  import dac_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4D,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       strapHi,
  input  logic       strapLo,
  output logic       sdaOe,
  output cfgStrobe_t strobe
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_IGNORE} state_t;

  localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};

  logic sclS, sdaS, sclD, sdaD;
  state_t state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic inAck, ackOk, byteOk;
  logic [1:0] regSel, byteIdx, byteLimit;

  dac_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));
  dac_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end

  wire sclRise  = sclS & ~sclD;
  wire sclFall  = ~sclS & sclD;
  wire startDet = sclS & sclD & sdaD & ~sdaS;
  wire stopDet  = sclS & sclD & ~sdaD & sdaS;
  wire busy     = (state == S_ADDR) || (state == S_SUB) || (state == S_DATA);

  assign byteLimit = (regSel == REG_VOL) ? 2'd2 : 2'd1;

  always_comb begin
    byteOk = 1'b0;
    case (state)
      S_ADDR: byteOk = (shiftReg == ADDR_WR);
      S_SUB:  byteOk = (shiftReg[7:6] == {strapHi, strapLo}) && (shiftReg[1:0] != 2'b00);
      S_DATA: byteOk = (byteIdx < byteLimit);
      default: byteOk = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      inAck    <= 1'b0;
      ackOk    <= 1'b0;
      sdaOe    <= 1'b0;
      regSel   <= '0;
      byteIdx  <= '0;
      strobe   <= '0;
    end else begin
      strobe.wrEn <= 1'b0;
      if (startDet) begin
        state   <= S_ADDR;
        bitCnt  <= '0;
        inAck   <= 1'b0;
        sdaOe   <= 1'b0;
        byteIdx <= '0;
      end else if (stopDet) begin
        state <= S_IDLE;
        inAck <= 1'b0;
        sdaOe <= 1'b0;
      end else if (busy) begin
        if (sclRise && !inAck) begin
          shiftReg <= {shiftReg[6:0], sdaS};
          bitCnt   <= bitCnt + 4'd1;
        end else if (sclFall) begin
          if (inAck) begin
            inAck  <= 1'b0;
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            if (!ackOk) state <= S_IGNORE;
            else begin
              case (state)
                S_ADDR: state <= S_SUB;
                S_SUB: begin
                  state   <= S_DATA;
                  byteIdx <= '0;
                end
                default: begin
                  strobe.wrEn    <= 1'b1;
                  strobe.regSel  <= regSel;
                  strobe.byteIdx <= byteIdx;
                  strobe.data    <= shiftReg;
                  byteIdx        <= byteIdx + 2'd1;
                end
              endcase
            end
          end else if (bitCnt == 4'd8) begin
            inAck <= 1'b1;
            ackOk <= byteOk;
            sdaOe <= byteOk;
            if (state == S_SUB) regSel <= shiftReg[1:0];
          end
        end
      end
    end

  AST_OE_IN_ACK: assert property (@(posedge clk) disable iff (!rstN) sdaOe |-> inAck); // R10
  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rstN) (state == S_IDLE) |-> !sdaOe); // R10
  AST_STROBE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN) strobe.wrEn |-> $past(sdaOe)); // R5
  AST_NACK_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN) (state == S_IGNORE) |-> !strobe.wrEn); // R3
endmodule

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs
  import dac_cfg_pkg::*;
#(
  parameter logic [5:0] VOL_DEFAULT = 6'b101100
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrobe_t strobe,
  output logic [2:0] rateCode,
  output logic       delayEn,
  output logic       lrSwap,
  output logic       oscForce,
  output logic       deemEn,
  output logic [5:0] volLeft,
  output logic [5:0] volRight,
  output logic       hiSupply,
  output logic [2:0] powerMode,
  output logic       aux2En,
  output logic       aux1En,
  output logic       auxMono,
  output logic       invRightAmp
);
  logic [4:0] rateReg;
  logic [7:0] cfgReg, volPend;
  logic [5:0] volLReg, volRReg;
  logic oscReg, deemReg, initDone;

  wire rateWr = strobe.wrEn && (strobe.regSel == REG_RATE);
  wire volLo  = strobe.wrEn && (strobe.regSel == REG_VOL) && (strobe.byteIdx == 2'd1);
  wire volHi  = strobe.wrEn && (strobe.regSel == REG_VOL) && (strobe.byteIdx == 2'd0);
  wire cfgWr  = strobe.wrEn && (strobe.regSel == REG_CFG);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rateReg  <= '0;
      cfgReg   <= '0;
      volPend  <= '0;
      volLReg  <= '0;
      volRReg  <= '0;
      oscReg   <= 1'b0;
      deemReg  <= 1'b0;
      initDone <= 1'b0;
    end else if (!initDone) begin
      volLReg  <= VOL_DEFAULT;
      volRReg  <= VOL_DEFAULT;
      initDone <= 1'b1;
    end else begin
      if (rateWr) rateReg <= strobe.data[4:0];
      if (cfgWr)  cfgReg  <= strobe.data;
      if (volHi)  volPend <= strobe.data;
      if (volLo) begin
        oscReg  <= volPend[7];
        deemReg <= volPend[6];
        volLReg <= volPend[5:0];
        volRReg <= strobe.data[5:0];
      end
    end

  assign lrSwap      = rateReg[4];
  assign delayEn     = rateReg[3];
  assign rateCode    = rateReg[2:0];
  assign oscForce    = oscReg;
  assign deemEn      = deemReg;
  assign volLeft     = volLReg;
  assign volRight    = volRReg;
  assign hiSupply    = cfgReg[7];
  assign powerMode   = cfgReg[6:4];
  assign aux2En      = cfgReg[3];
  assign aux1En      = cfgReg[2];
  assign auxMono     = cfgReg[1];
  assign invRightAmp = cfgReg[0];

  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rstN) (initDone && !rateWr) |=> $stable({lrSwap, delayEn, rateCode})); // R6
  AST_VOL_ATOMIC: assert property (@(posedge clk) disable iff (!rstN) (initDone && !volLo) |=> $stable({oscForce, deemEn, volLeft, volRight})); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN) (initDone && !cfgWr) |=> $stable({hiSupply, powerMode, aux2En, aux1En, auxMono, invRightAmp})); // R8
endmodule

// File: rtl/dac_cfg_i2c.sv
module dac_cfg_i2c
  import dac_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4D,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] VOL_DEFAULT = 6'b101100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic       strapHi,
  input  logic       strapLo,
  output logic [2:0] rateCode,
  output logic       delayEn,
  output logic       lrSwap,
  output logic       oscForce,
  output logic       deemEn,
  output logic [5:0] volLeft,
  output logic [5:0] volRight,
  output logic       hiSupply,
  output logic [2:0] powerMode,
  output logic       aux2En,
  output logic       aux1En,
  output logic       auxMono,
  output logic       invRightAmp
);
  cfgStrobe_t strobe;

  dac_cfg_ctrl #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strapHi(strapHi), .strapLo(strapLo), .sdaOe(sdaOe), .strobe(strobe));

  dac_cfg_regs #(.VOL_DEFAULT(VOL_DEFAULT)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rateCode(rateCode), .delayEn(delayEn), .lrSwap(lrSwap),
    .oscForce(oscForce), .deemEn(deemEn), .volLeft(volLeft), .volRight(volRight),
    .hiSupply(hiSupply), .powerMode(powerMode), .aux2En(aux2En), .aux1En(aux1En),
    .auxMono(auxMono), .invRightAmp(invRightAmp));
endmodule

// File: tb/sim_dac_cfg_i2c.sv
module sim_dac_cfg_i2c;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic strapHi = 1'b0, strapLo = 1'b0;
  logic sdaOe;
  logic [2:0] rateCode, powerMode;
  logic delayEn, lrSwap, oscForce, deemEn, hiSupply, aux2En, aux1En, auxMono, invRightAmp;
  logic [5:0] volLeft, volRight;
  wire sdaLine = sdaM & ~sdaOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [4:0] expRate;
  logic [15:0] expVol;
  logic [7:0] expCfg;

  always #2 clk = ~clk;

  dac_cfg_i2c u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapHi(strapHi), .strapLo(strapLo), .rateCode(rateCode), .delayEn(delayEn),
    .lrSwap(lrSwap), .oscForce(oscForce), .deemEn(deemEn), .volLeft(volLeft),
    .volRight(volRight), .hiSupply(hiSupply), .powerMode(powerMode), .aux2En(aux2En),
    .aux1En(aux1En), .auxMono(auxMono), .invRightAmp(invRightAmp));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(1);
      sclM = 1'b1; waitQ(2);
      sclM = 1'b0; waitQ(1);
    end
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    ackd = ~sdaLine;
    waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic checkFields(input string tag);
    chk({tag, " R6 rate"}, {27'd0, lrSwap, delayEn, rateCode}, {27'd0, expRate});
    chk({tag, " R7 volume"}, {16'd0, oscForce, deemEn, volLeft, 2'b00, volRight}, {16'd0, expVol});
    chk({tag, " R8 config"}, {24'd0, hiSupply, powerMode, aux2En, aux1En, auxMono, invRightAmp}, {24'd0, expCfg});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] sub, d0, d1;
    logic acc;
    // R9: reset clears everything, then defaults load
    repeat (5) @(negedge clk);
    chk("R9 volume in reset", {20'd0, volLeft, volRight}, 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    expRate = '0; expCfg = '0; expVol = {2'b00, 6'b101100, 2'b00, 6'b101100};
    checkFields("R9 after reset");
    chk("R10 released at idle", {31'd0, sdaOe}, 32'd0);

    // R1: wrong address and read bit are refused
    busStart(); sendByte(8'h98, a); chk("R1 wrong address nack", {31'd0, a}, 32'd0);
    sendByte(8'h01, a); chk("R1 follow-on nack", {31'd0, a}, 32'd0);
    sendByte(8'hFF, a); busStop();
    busStart(); sendByte(8'h9B, a); chk("R1 read bit nack", {31'd0, a}, 32'd0);
    sendByte(8'h03, a); sendByte(8'hFF, a); busStop();
    checkFields("R1 unchanged");

    // Sweep: all straps x chip selects x register indexes (R2 R3 R4 R5)
    for (int st = 0; st < 4; st++) begin
      for (int cs = 0; cs < 4; cs++) begin
        for (int ra = 0; ra < 4; ra++) begin
          {strapHi, strapLo} = st[1:0];
          sub = {cs[1:0], 2'(st + cs), 2'(cs), ra[1:0]};
          d0 = 8'((st * 37 + cs * 11 + ra * 5 + 3) & 255);
          d1 = 8'((d0 * 7 + 1) & 255);
          acc = (cs == st) && (ra != 0);
          busStart();
          sendByte(8'h9A, a); chk("R1 address ack", {31'd0, a}, 32'd1);
          sendByte(sub, a);
          chk(ra == 0 ? "R3 subaddress ack" : "R2 subaddress ack", {31'd0, a}, {31'd0, acc});
          sendByte(d0, a); chk("R5 first data ack", {31'd0, a}, {31'd0, acc});
          if (ra == 2) begin
            if (acc) checkFields("R4 after high byte");
            sendByte(d1, a); chk("R4 second data ack", {31'd0, a}, {31'd0, acc});
          end
          sendByte(8'hA5, a); chk("R5 extra byte nack", {31'd0, a}, 32'd0);
          busStop();
          if (acc) begin
            if (ra == 1) expRate = d0[4:0];
            if (ra == 3) expCfg = d0;
            if (ra == 2) expVol = {d0, 2'b00, d1[5:0]};
          end
          checkFields("R2 sweep");
          chk("R10 released after stop", {31'd0, sdaOe}, 32'd0);
        end
      end
    end

    // R11: repeated start abandons a half-written volume
    {strapHi, strapLo} = 2'b01;
    busStart(); sendByte(8'h9A, a); sendByte(8'h42, a);
    sendByte(8'hC7, a); chk("R11 high byte ack", {31'd0, a}, 32'd1);
    busStart(); sendByte(8'h9A, a); chk("R11 address after restart", {31'd0, a}, 32'd1);
    sendByte(8'h41, a); sendByte(8'h1A, a); busStop();
    expRate = 5'h1A;
    checkFields("R11 restart");
    busStart(); sendByte(8'h9A, a); sendByte(8'h42, a);
    sendByte(8'h8E, a); sendByte(8'h3F, a); busStop();
    expVol = {8'h8E, 2'b00, 6'h3F};
    checkFields("R11 full volume");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule